// File: doc/BRIEF.md
# Prefetching Instruction Fetch Sequencer

This block is the instruction fetch front end of a small accumulator machine. It keeps a program counter, an address register that drives a single-port instruction memory, a one-entry data buffer with a valid flag, and the instruction register that the execute stage reads. Whenever the buffer is free it starts a read and advances the program counter. The returned word is parked in the buffer until the executing instruction reports completion. The word then moves to the instruction register, and the next read starts on the same edge.

The execute side steers the fetch with three inputs. A jump request redirects the program counter and throws away any buffered or in-flight word. A stall request stops new reads and inserts a no-operation in place of a real instruction while a fetch address is still unresolved. A completion pulse advances the instruction stream. The memory is expected to return the word addressed by `mem_addr_o` during the cycle in which `mem_rd_o` is high, so each read takes one cycle after the address register is loaded.

Top module: `fetch_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `pc_o` = 0, `cir_o` = NOP (parameter, default all zeros) and `mem_rd_o` = 0.
- R2: When no read is in flight, the buffer is free or being emptied, and neither jump nor stall is requested, the next cycle shows `mem_rd_o` = 1, `mem_addr_o` equal to the previous `pc_o`, and `pc_o` one higher, wrapping from the top address to 0.
- R3: The word present on `mem_rdata_i` in a cycle with `mem_rd_o` = 1 is held in the buffer. No further read is started while the buffer is full and not being emptied.
- R4: At an edge where `done_i` = 1, the buffer is full and neither jump nor stall is requested, `cir_o` takes the buffered word.
- R5: At an edge where `done_i` = 1 and the buffer is empty (including the edge on which the word is still arriving), `cir_o` becomes NOP.
- R6: With `done_i`, `jump_i` and `stall_i` all 0, `cir_o` keeps its value.
- R7: A jump request sets `pc_o` to `jump_tgt_i` on the next cycle, discards the buffered word and any read in flight, and the following read uses the target address.
- R8: A jump together with a completion pulse loads NOP into `cir_o`. The discarded word never reaches `cir_o`.
- R9: While `stall_i` = 1, no new read starts (a read already in flight still lands in the buffer), and a completion pulse loads NOP. After release the buffered word is delivered by the next completion pulse.
- R10: The read for the following instruction starts on the same edge that moves a word into `cir_o`, so fetch overlaps execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Executing instruction has completed |
| jump_i | input | 1 | Redirect fetch to `jump_tgt_i` |
| jump_tgt_i | input | AW | Jump target address |
| stall_i | input | 1 | Fetch address not yet known; hold fetch, feed NOP |
| mem_rdata_i | input | DW | Instruction memory read data |
| mem_addr_o | output | AW | Instruction memory address (address register) |
| mem_rd_o | output | 1 | Read in progress; data valid this cycle |
| pc_o | output | AW | Program counter |
| cir_o | output | DW | Current instruction register |

## Verification
The hardest cases are the edges where two events fall on the same cycle. One is a completion pulse that arrives while the next word is still on the memory bus. Another is a jump that meets a full buffer, or a read still in flight. The bench reaches these by driving completion pulses back to back right after a sweep of paced pulses, and by issuing jumps both one cycle after a read starts and one cycle after it lands. The memory holds a computed, never-NOP word per address, so any stale or misrouted word shows up at `cir_o`.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [DW-1:0] NOP = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done_i,
  input  logic          jump_i,
  input  logic [AW-1:0] jump_tgt_i,
  input  logic          stall_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] cir_o
);
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mdr_q, cir_q;
  logic          mdr_v, pend;

  wire take  = done_i && !jump_i && !stall_i && mdr_v;
  wire issue = !jump_i && !stall_i && !pend && (!mdr_v || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      mdr_v <= 1'b0;
      pend  <= 1'b0;
      cir_q <= NOP;
    end else if (jump_i) begin
      pc_q  <= jump_tgt_i;
      mdr_v <= 1'b0;
      pend  <= 1'b0;
      cir_q <= NOP;
    end else begin
      if (take) mdr_v <= 1'b0;
      if (pend) begin
        mdr_q <= mem_rdata_i;
        mdr_v <= 1'b1;
        pend  <= 1'b0;
      end
      if (issue) begin
        mar_q <= pc_q;
        pc_q  <= pc_q + 1'b1;
        pend  <= 1'b1;
      end
      if (done_i) cir_q <= take ? mdr_q : NOP;
    end
  end

  assign mem_addr_o = mar_q;
  assign mem_rd_o   = pend;
  assign pc_o       = pc_q;
  assign cir_o      = cir_q;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && cir_q == NOP && !pend));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    issue |=> (mar_q == $past(pc_q) && pc_q == $past(pc_q) + 1'b1 && pend));

  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (pend && !jump_i) |=> (mdr_v && mdr_q == $past(mem_rdata_i)));

  p_xfer_r4: assert property (@(posedge clk) disable iff (rst)
    take |=> (cir_q == $past(mdr_q)));

  p_empty_nop_r5: assert property (@(posedge clk) disable iff (rst)
    (done_i && !mdr_v) |=> (cir_q == NOP));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!done_i && !jump_i && !stall_i) |=> $stable(cir_q));

  p_jump_r7: assert property (@(posedge clk) disable iff (rst)
    jump_i |=> (pc_q == $past(jump_tgt_i) && !mdr_v && !pend));

  p_jump_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (jump_i && done_i) |=> (cir_q == NOP));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !jump_i) |=> !pend);

  p_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    (take && !pend) |=> pend);
endmodule

// File: tb/fetch_seq_test.sv
module fetch_seq_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [DW-1:0] NOP = '0;

  logic          clk = 0;
  logic          rst = 1;
  logic          done_i = 0, jump_i = 0, stall_i = 0;
  logic [AW-1:0] jump_tgt_i = '0;
  logic [DW-1:0] mem_rdata_i;
  logic [AW-1:0] mem_addr_o, pc_o;
  logic          mem_rd_o;
  logic [DW-1:0] cir_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] word(input logic [AW-1:0] a);
    return {a ^ 8'hC3, a};
  endfunction

  assign mem_rdata_i = word(mem_addr_o);

  fetch_seq #(.AW(AW), .DW(DW), .NOP(NOP)) uut (
    .clk(clk), .rst(rst), .done_i(done_i), .jump_i(jump_i),
    .jump_tgt_i(jump_tgt_i), .stall_i(stall_i), .mem_rdata_i(mem_rdata_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .pc_o(pc_o), .cir_o(cir_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic d, input logic j, input logic [AW-1:0] t, input logic s);
    done_i = d; jump_i = j; jump_tgt_i = t; stall_i = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R1 pc", pc_o, 0);
    chk("R1 cir", cir_o, NOP);
    chk("R1 rd", mem_rd_o, 0);
    rst = 0;
    cyc(0, 0, 0, 0);
    chk("R2 rd", mem_rd_o, 1);
    chk("R2 addr", mem_addr_o, 0);
    chk("R2 pc", pc_o, 1);
    cyc(0, 0, 0, 0);
    chk("R3 no reissue", mem_rd_o, 0);
    cyc(0, 0, 0, 0);
    chk("R3 still idle", mem_rd_o, 0);
    chk("R6 cir held", cir_o, NOP);
    cyc(1, 0, 0, 0);
    chk("R4 cir", cir_o, word(0));
    chk("R10 overlap rd", mem_rd_o, 1);
    chk("R10 overlap addr", mem_addr_o, 1);
    cyc(0, 0, 0, 0);
    chk("R6 cir held", cir_o, word(0));
    for (int k = 1; k <= 30; k++) begin
      cyc(1, 0, 0, 0);
      chk("R4 sweep cir", cir_o, word(AW'(k)));
      chk("R10 sweep addr", mem_addr_o, k + 1);
      chk("R2 sweep pc", pc_o, k + 2);
      cyc(0, 0, 0, 0);
      chk("R6 sweep hold", cir_o, word(AW'(k)));
      chk("R3 sweep idle", mem_rd_o, 0);
    end
    cyc(1, 0, 0, 0);
    chk("R4 cir 31", cir_o, word(31));
    cyc(1, 0, 0, 0);
    chk("R5 empty nop", cir_o, NOP);
    cyc(0, 0, 0, 0);
    chk("R3 full no reissue", mem_rd_o, 0);
    cyc(1, 0, 0, 0);
    chk("R3 held word", cir_o, word(32));
    chk("R2 pc 34", pc_o, 34);
    cyc(0, 1, 8'h80, 0);
    chk("R7 pc", pc_o, 8'h80);
    chk("R7 inflight dropped", mem_rd_o, 0);
    cyc(0, 0, 0, 0);
    chk("R7 new addr", mem_addr_o, 8'h80);
    chk("R7 pc+1", pc_o, 8'h81);
    cyc(0, 0, 0, 0);
    cyc(1, 1, 8'h40, 0);
    chk("R8 jump wins", cir_o, NOP);
    chk("R8 pc", pc_o, 8'h40);
    cyc(0, 0, 0, 0);
    chk("R7 addr 40", mem_addr_o, 8'h40);
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    chk("R8 no stale", cir_o, word(8'h40));
    cyc(0, 0, 0, 1);
    chk("R9 no issue", mem_rd_o, 0);
    cyc(1, 0, 0, 1);
    chk("R9 nop", cir_o, NOP);
    chk("R9 no issue 2", mem_rd_o, 0);
    cyc(0, 0, 0, 1);
    chk("R9 pc held", pc_o, 8'h42);
    cyc(1, 0, 0, 0);
    chk("R9 delivered", cir_o, word(8'h41));
    chk("R9 resume addr", mem_addr_o, 8'h42);
    chk("R2 pc 43", pc_o, 8'h43);
    cyc(0, 0, 0, 0);
    cyc(0, 1, 8'hFF, 0);
    chk("R7 pc ff", pc_o, 8'hFF);
    cyc(0, 0, 0, 0);
    chk("R2 wrap addr", mem_addr_o, 8'hFF);
    chk("R2 wrap pc", pc_o, 0);
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    chk("R4 word ff", cir_o, word(8'hFF));
    chk("R10 wrap addr", mem_addr_o, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule